// File: doc/BRIEF.md
# SPI NOR Flash Program and Erase Sequencer

This block sits on the host side of a serial NOR flash and turns a one-cycle local request into the full serial transaction a modifying flash command needs. A request names one of three operations: a page write of any length, erasure of the sector holding an address, or erasure of the whole device. It also carries a 24-bit byte address and, for writes, a byte count. The sequencer sends a write-enable frame on its own, then the operation frame. It then reads the status register again and again until the busy flag drops, and only then reports completion.

Write data is pulled from a show-ahead byte source: `wr_byte` must always hold the next byte, and `wr_pop` pulses once for each byte taken. A write that runs over a 256-byte page edge is cut into several page operations. Each of them gets its own write-enable, program frame and polling loop. The serial side runs in SPI mode 0. The serial clock is the system clock divided by `CLK_DIV`, and chip select rises between every pair of frames.

Top module: `spi_flash_prog_seq`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, `busy` and `done` are 0; `spi_sclk` is 0 in every cycle where `spi_cs_n` is 1.
- R2: Bits travel MSB first in mode 0. `spi_mosi` changes only while `spi_sclk` is low, and `spi_miso` is captured at each rising edge. The shortest `spi_sclk` period is `CLK_DIV` system clocks.
- R3: Each modifying frame (opcode 02h, D8h or C7h) is preceded by its own one-byte frame carrying 06h.
- R4: A sector erase (`req_op` = 1) sends the frame D8h followed by the three address bytes, most significant first. A device erase (`req_op` = 2) sends the one-byte frame C7h.
- R5: A page write (`req_op` = 0) sends 02h, then three address bytes, then data bytes in stream order. One `wr_pop` pulse is given per byte sent, and only while `spi_cs_n` is low.
- R6: A write that crosses a 256-byte page edge is split. The first program frame carries 256 minus the low address byte (or fewer, if fewer remain). Each later frame starts on a page-aligned address. Each piece gets its own write-enable and polling.
- R7: After each operation frame, a two-byte status frame (05h, then a dummy byte) is repeated while status bit 0 reads 1. `done` rises only after a read with bit 0 at 0.
- R8: After `spi_cs_n` rises it stays high for at least `CS_HIGH_MIN` system clocks, with `CS_HIGH_MIN` at least 2.
- R9: If `POLL_LIMIT` status reads in a row all show bit 0 set, the sequencer stops polling and pulses `done` and `err` together.
- R10: A page write of length 0, or `req_op` = 3, completes with a `done` pulse one cycle after acceptance and no serial activity.
- R11: `done` is a single-cycle pulse, and `err` is high only together with `done`. A request is taken only when `busy` is 0; a request made while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 2 | 0 page write, 1 sector erase, 2 device erase, 3 no operation |
| req_addr | input | 24 | Target byte address |
| req_len | input | LEN_W | Write byte count |
| wr_byte | input | 8 | Show-ahead head of the write byte stream |
| wr_pop | output | 1 | Consumes the current wr_byte |
| busy | output | 1 | A request is being carried out |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Busy-poll timeout, valid with done |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Assertions check the following on every cycle:
- the clock stays low while chip select is high;
- the outgoing data line does not move while the clock is high;
- chip select is held high after each rise;
- the shifter is never restarted mid-byte;
- byte pops happen only inside a frame;
- `done` and `err` are pulses shaped as required.

Only the bench scenarios can show the order and content of frames. That covers the write-enable before each operation, the split points of a long write, the number of status polls against a flash model that holds its busy flag for a set count, and the timeout outcome.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    localparam int ADDR_W = 24;

    typedef enum logic [1:0] {
        REQ_PAGE   = 2'd0,
        REQ_SECTOR = 2'd1,
        REQ_CHIP   = 2'd2,
        REQ_NONE   = 2'd3
    } req_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GAP   = 3'd1,
        ST_WREN  = 3'd2,
        ST_OPC   = 3'd3,
        ST_ADDR  = 3'd4,
        ST_DATA  = 3'd5,
        ST_POLLC = 3'd6,
        ST_POLLR = 3'd7
    } seq_st_e;

    localparam logic [7:0] CMD_WEN  = 8'h06;
    localparam logic [7:0] CMD_PROG = 8'h02;
    localparam logic [7:0] CMD_SECT = 8'hD8;
    localparam logic [7:0] CMD_CHIP = 8'hC7;
    localparam logic [7:0] CMD_STAT = 8'h05;
    localparam logic [7:0] WIP_MASK = 8'h01;

endpackage

// File: rtl/sfp_byte_shifter.sv
module sfp_byte_shifter #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic          busy;
        logic          sclk;
        logic [CW-1:0] cnt;
        logic [2:0]    bitn;
        logic [7:0]    tx;
        logic [7:0]    rx;
    } sh_t;

    sh_t q, n;

    always_comb begin
        n    = q;
        done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                n.busy = 1'b1;
                n.tx   = tx_byte;
                n.cnt  = '0;
                n.bitn = '0;
                n.sclk = 1'b0;
            end
        end else if (q.cnt == CW'(HALF - 1)) begin
            n.cnt = '0;
            if (!q.sclk) begin
                n.sclk = 1'b1;
                n.rx   = {q.rx[6:0], miso};
            end else begin
                n.sclk = 1'b0;
                if (q.bitn == 3'd7) begin
                    n.busy = 1'b0;
                    done   = 1'b1;
                end else begin
                    n.bitn = q.bitn + 3'd1;
                    n.tx   = {q.tx[6:0], 1'b0};
                end
            end
        end else begin
            n.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy    = q.busy;
    assign rx_byte = q.rx;
    assign sclk    = q.sclk;
    assign mosi    = q.tx[7];

    assert_mosi_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.sclk |-> $stable(q.tx[7]));
    assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.busy);

endmodule

// File: rtl/sfp_seq_ctl.sv
module sfp_seq_ctl
    import sfp_pkg::*;
#(
    parameter int LEN_W       = 12,
    parameter int CS_HIGH_MIN = 2,
    parameter int POLL_LIMIT  = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        wr_byte,
    output logic              wr_pop,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              spi_cs_n,
    output logic              sh_start,
    output logic [7:0]        sh_tx,
    input  logic              sh_busy,
    input  logic              sh_done,
    input  logic [7:0]        sh_rx
);
    localparam int GAP_W  = (CS_HIGH_MIN > 1) ? $clog2(CS_HIGH_MIN) : 1;
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        seq_st_e           st;
        seq_st_e           after;
        logic              cs_n;
        logic              launched;
        req_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
        logic [1:0]        aidx;
        logic [GAP_W-1:0]  gap;
        logic [POLL_W-1:0] polls;
        logic              done;
        logic              err;
    } sq_t;

    sq_t q, n;
    logic go, wip;

    function automatic sq_t close_frame(sq_t s, seq_st_e nxt);
        s.launched = 1'b0;
        s.cs_n     = 1'b1;
        s.st       = ST_GAP;
        s.gap      = '0;
        s.after    = nxt;
        return s;
    endfunction

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        n.err    = 1'b0;
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        wr_pop   = 1'b0;
        go       = !sh_busy && !q.launched;
        wip      = |(sh_rx & WIP_MASK);
        if (q.st != ST_IDLE && q.st != ST_GAP && go) begin
            sh_start   = 1'b1;
            n.launched = 1'b1;
            n.cs_n     = 1'b0;
        end
        case (q.st)
            ST_IDLE: if (req_valid) begin
                n.op    = req_op_e'(req_op);
                n.addr  = req_addr;
                n.left  = req_len;
                n.polls = '0;
                if (req_op_e'(req_op) == REQ_NONE ||
                    (req_op_e'(req_op) == REQ_PAGE && req_len == '0)) begin
                    n.done = 1'b1;
                end else begin
                    n = close_frame(n, ST_WREN);
                end
            end
            ST_GAP: begin
                if (q.gap >= GAP_W'(CS_HIGH_MIN - 1)) n.st = q.after;
                else                                 n.gap = q.gap + 1'b1;
            end
            ST_WREN: begin
                sh_tx = CMD_WEN;
                if (sh_done) n = close_frame(n, ST_OPC);
            end
            ST_OPC: begin
                case (q.op)
                    REQ_PAGE:   sh_tx = CMD_PROG;
                    REQ_SECTOR: sh_tx = CMD_SECT;
                    default:    sh_tx = CMD_CHIP;
                endcase
                if (sh_done) begin
                    if (q.op == REQ_CHIP) begin
                        n = close_frame(n, ST_POLLC);
                    end else begin
                        n.launched = 1'b0;
                        n.st       = ST_ADDR;
                        n.aidx     = '0;
                    end
                end
            end
            ST_ADDR: begin
                case (q.aidx)
                    2'd0:    sh_tx = q.addr[23:16];
                    2'd1:    sh_tx = q.addr[15:8];
                    default: sh_tx = q.addr[7:0];
                endcase
                if (sh_done) begin
                    n.launched = 1'b0;
                    if (q.aidx == 2'd2) begin
                        if (q.op == REQ_SECTOR) n = close_frame(n, ST_POLLC);
                        else                    n.st = ST_DATA;
                    end else begin
                        n.aidx = q.aidx + 2'd1;
                    end
                end
            end
            ST_DATA: begin
                sh_tx  = wr_byte;
                wr_pop = go;
                if (sh_done) begin
                    n.addr     = q.addr + 24'd1;
                    n.left     = q.left - 1'b1;
                    n.launched = 1'b0;
                    if (q.left == LEN_W'(1) || q.addr[7:0] == 8'hFF)
                        n = close_frame(n, ST_POLLC);
                end
            end
            ST_POLLC: begin
                sh_tx = CMD_STAT;
                if (sh_done) begin
                    n.launched = 1'b0;
                    n.st       = ST_POLLR;
                end
            end
            default: begin
                sh_tx = 8'h00;
                if (sh_done) begin
                    if (!wip) begin
                        if (q.op == REQ_PAGE && q.left != '0) begin
                            n       = close_frame(n, ST_WREN);
                            n.polls = '0;
                        end else begin
                            n          = close_frame(n, ST_IDLE);
                            n.st       = ST_IDLE;
                            n.done     = 1'b1;
                        end
                    end else if (q.polls == POLL_W'(POLL_LIMIT - 1)) begin
                        n      = close_frame(n, ST_IDLE);
                        n.st   = ST_IDLE;
                        n.done = 1'b1;
                        n.err  = 1'b1;
                    end else begin
                        n       = close_frame(n, ST_POLLC);
                        n.polls = q.polls + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign err      = q.err;
    assign spi_cs_n = q.cs_n;

    assert_cs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.cs_n) |=> q.cs_n);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> q.done);
    assert_pop_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pop |-> !q.cs_n);
    assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> q.cs_n);

endmodule

// File: rtl/spi_flash_prog_seq.sv
module spi_flash_prog_seq
    import sfp_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int LEN_W       = 12,
    parameter int CS_HIGH_MIN = 2,
    parameter int POLL_LIMIT  = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        wr_byte,
    output logic              wr_pop,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic       sh_start, sh_busy, sh_done;
    logic [7:0] sh_tx, sh_rx;

    sfp_seq_ctl #(
        .LEN_W(LEN_W), .CS_HIGH_MIN(CS_HIGH_MIN), .POLL_LIMIT(POLL_LIMIT)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
        .wr_byte(wr_byte), .wr_pop(wr_pop),
        .busy(busy), .done(done), .err(err), .spi_cs_n(spi_cs_n),
        .sh_start(sh_start), .sh_tx(sh_tx), .sh_busy(sh_busy),
        .sh_done(sh_done), .sh_rx(sh_rx)
    );

    sfp_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start(sh_start), .tx_byte(sh_tx), .busy(sh_busy), .done(sh_done),
        .rx_byte(sh_rx), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
    );

    assert_sclk_low_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

endmodule

// File: tb/spi_flash_prog_seq_test.sv
module spi_flash_prog_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 4;
    localparam int LEN_W      = 12;
    localparam int CS_MIN     = 2;
    localparam int POLL_LIM   = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [23:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [7:0] wr_byte;
    logic wr_pop, busy, done, err, spi_cs_n, spi_sclk, spi_mosi;
    logic spi_miso = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_flash_prog_seq #(
        .CLK_DIV(CLK_DIV), .LEN_W(LEN_W), .CS_HIGH_MIN(CS_MIN), .POLL_LIMIT(POLL_LIM)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .wr_byte(wr_byte), .wr_pop(wr_pop),
        .busy(busy), .done(done), .err(err), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0, errors = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    // write byte source, show-ahead
    int pop_idx = 0;
    assign wr_byte = pat(pop_idx);
    always @(posedge clk) if (wr_pop) pop_idx <= pop_idx + 1;

    // flash model and frame recorder
    int fr_cnt = 0;
    int fr_len [64];
    logic [7:0] fr_b [64][264];
    int bitc = 0;
    logic [7:0] sh_in = '0, st_sr = '0;
    logic wel = 1'b0;
    int wip_left = 0, wip_preset = 0, wel_viol = 0;

    always @(negedge spi_cs_n) bitc = 0;

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        sh_in = {sh_in[6:0], spi_mosi};
        bitc++;
        if (bitc % 8 == 0) begin
            if (fr_cnt < 64 && bitc / 8 <= 264) fr_b[fr_cnt][bitc/8 - 1] = sh_in;
            if (bitc == 8 && sh_in == 8'h05) st_sr = {6'b0, wel, (wip_left > 0)};
        end
    end

    always @(negedge spi_sclk) if (!spi_cs_n && bitc >= 8) begin
        spi_miso = st_sr[7];
        st_sr    = {st_sr[6:0], 1'b0};
    end

    always @(posedge spi_cs_n) if (bitc > 0 && fr_cnt < 64) begin
        fr_len[fr_cnt] = bitc / 8;
        case (fr_b[fr_cnt][0])
            8'h06: wel = 1'b1;
            8'h02, 8'hD8, 8'hC7: begin
                if (!wel) wel_viol++;
                wel = 1'b0;
                wip_left = wip_preset;
            end
            8'h05: if (wip_left > 0) wip_left--;
            default: ;
        endcase
        fr_cnt++;
        bitc = 0;
    end

    // timing monitors
    int cyc = 0, hi_run = 0, min_hi = 1000, last_rise = -1, min_per = 1000, dw = 0, max_dw = 0;
    always @(posedge clk) begin
        cyc++;
        if (spi_cs_n) hi_run++;
        else begin
            if (hi_run > 0 && hi_run < min_hi) min_hi = hi_run;
            hi_run = 0;
        end
        if (done) dw++; else dw = 0;
        if (dw > max_dw) max_dw = dw;
    end
    always @(posedge spi_sclk) begin
        if (last_rise >= 0 && cyc - last_rise < min_per) min_per = cyc - last_rise;
        last_rise = cyc;
    end

    task automatic clear_model(int preset);
        fr_cnt = 0; wel = 1'b0; wel_viol = 0; wip_left = 0; wip_preset = preset;
        pop_idx = 0; max_dw = 0;
    endtask

    task automatic start_req(logic [1:0] op, logic [23:0] a, int len);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_len = LEN_W'(len);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output bit got, output logic e);
        got = 0; e = 1'b0;
        for (int i = 0; i < 60000; i++) begin
            if (done) begin got = 1; e = err; break; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(spi_cs_n === 1'b1, "R1", "cs_n in reset", spi_cs_n, 1);
        chk(spi_sclk === 1'b0, "R1", "sclk in reset", spi_sclk, 0);
        chk(busy === 1'b0, "R1", "busy in reset", busy, 0);
        chk(done === 1'b0, "R1", "done in reset", done, 0);
    endtask

    task automatic t_sector();
        bit got; logic e;
        clear_model(2);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_addr = 24'h123456;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        repeat (40) @(negedge clk);
        req_valid = 1'b1; req_op = 2'd2;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(got, e);
        chk(got, "R7", "sector done seen", got, 1);
        chk(e === 1'b0, "R9", "sector err", e, 0);
        repeat (30) @(negedge clk);
        chk(fr_cnt == 5, "R11", "frames incl. ignored request", fr_cnt, 5);
        chk(busy === 1'b0, "R11", "idle after op", busy, 0);
        chk(fr_len[0] == 1 && fr_b[0][0] == 8'h06, "R3", "write-enable frame", fr_b[0][0], 8'h06);
        chk(fr_len[1] == 4 && fr_b[1][0] == 8'hD8, "R4", "sector opcode", fr_b[1][0], 8'hD8);
        chk({fr_b[1][1], fr_b[1][2], fr_b[1][3]} == 24'h123456, "R4", "sector address",
            {fr_b[1][1], fr_b[1][2], fr_b[1][3]}, 24'h123456);
        for (int k = 2; k < 5; k++)
            chk(fr_len[k] == 2 && fr_b[k][0] == 8'h05, "R7", "status poll frame", fr_b[k][0], 8'h05);
        chk(wel_viol == 0, "R3", "ops without enable", wel_viol, 0);
        chk(max_dw == 1, "R11", "done pulse width", max_dw, 1);
        chk(min_per == CLK_DIV, "R2", "min sclk period", min_per, CLK_DIV);
    endtask

    task automatic t_chip();
        bit got; logic e;
        clear_model(0);
        start_req(2'd2, 24'h0, 0);
        wait_done(got, e);
        @(negedge clk);
        chk(got && fr_cnt == 3, "R4", "device erase frame count", fr_cnt, 3);
        chk(fr_b[0][0] == 8'h06 && fr_len[1] == 1 && fr_b[1][0] == 8'hC7, "R4", "device erase opcode",
            fr_b[1][0], 8'hC7);
        chk(fr_len[2] == 2 && fr_b[2][0] == 8'h05, "R7", "single poll when ready", fr_b[2][0], 8'h05);
    endtask

    task automatic t_page_small();
        bit got; logic e; int bad = 0;
        clear_model(0);
        start_req(2'd0, 24'h000400, 5);
        wait_done(got, e);
        @(negedge clk);
        chk(got && fr_cnt == 3, "R5", "small write frame count", fr_cnt, 3);
        chk(fr_len[1] == 9 && fr_b[1][0] == 8'h02, "R5", "program frame length", fr_len[1], 9);
        chk({fr_b[1][1], fr_b[1][2], fr_b[1][3]} == 24'h000400, "R5", "program address",
            {fr_b[1][1], fr_b[1][2], fr_b[1][3]}, 24'h000400);
        for (int k = 0; k < 5; k++) if (fr_b[1][4+k] != pat(k)) bad++;
        chk(bad == 0, "R5", "data mismatches", bad, 0);
        chk(pop_idx == 5, "R5", "bytes popped", pop_idx, 5);
    endtask

    task automatic t_page_split();
        bit got; logic e; int a = 24'h0012F0, left = 600, g = 0, f = 0, ch, bad;
        clear_model(1);
        min_hi = 1000;
        start_req(2'd0, 24'h0012F0, 600);
        wait_done(got, e);
        @(negedge clk);
        chk(got && e === 1'b0, "R6", "split write done", got, 1);
        chk(fr_cnt == 16, "R6", "split frame count", fr_cnt, 16);
        while (left > 0 && f + 3 < 64) begin
            ch = (left < 256 - (a & 255)) ? left : 256 - (a & 255);
            chk(fr_b[f][0] == 8'h06, "R3", "enable before piece", fr_b[f][0], 8'h06);
            chk(fr_len[f+1] == 4 + ch, "R6", "piece length", fr_len[f+1] - 4, ch);
            chk({fr_b[f+1][1], fr_b[f+1][2], fr_b[f+1][3]} == 24'(a), "R6", "piece address",
                {fr_b[f+1][1], fr_b[f+1][2], fr_b[f+1][3]}, a);
            bad = 0;
            for (int k = 0; k < ch && k < 260; k++) if (fr_b[f+1][4+k] != pat(g + k)) bad++;
            chk(bad == 0, "R5", "piece data mismatches", bad, 0);
            chk(fr_b[f+2][0] == 8'h05 && fr_b[f+3][0] == 8'h05, "R7", "two polls per piece",
                fr_b[f+3][0], 8'h05);
            f += 4; a += ch; g += ch; left -= ch;
        end
        chk(pop_idx == 600, "R5", "total popped", pop_idx, 600);
        chk(wel_viol == 0, "R3", "ops without enable", wel_viol, 0);
        chk(min_hi >= CS_MIN, "R8", "min cs high cycles", min_hi, CS_MIN);
    endtask

    task automatic t_timeout();
        bit got; logic e;
        clear_model(1000);
        start_req(2'd1, 24'h070000, 0);
        wait_done(got, e);
        chk(got && e === 1'b1, "R9", "timeout error flag", e, 1);
        @(negedge clk);
        chk(err === 1'b0, "R11", "err dropped after pulse", err, 0);
        repeat (20) @(negedge clk);
        chk(fr_cnt == 2 + POLL_LIM, "R9", "polls before timeout", fr_cnt - 2, POLL_LIM);
        chk(busy === 1'b0, "R9", "idle after timeout", busy, 0);
        wip_left = 0;
    endtask

    task automatic t_zero();
        bit got; logic e;
        clear_model(0);
        start_req(2'd0, 24'h000100, 0);
        chk(done === 1'b1, "R10", "zero-length done next cycle", done, 1);
        repeat (10) @(negedge clk);
        chk(fr_cnt == 0 && pop_idx == 0, "R10", "zero-length traffic", fr_cnt, 0);
        start_req(2'd3, 24'h000100, 7);
        chk(done === 1'b1 && err === 1'b0, "R10", "no-op done", done, 1);
        wait_done(got, e);
        repeat (10) @(negedge clk);
        chk(fr_cnt == 0 && spi_cs_n === 1'b1, "R10", "no-op traffic", fr_cnt, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_sector();
        t_chip();
        t_page_small();
        t_page_split();
        t_timeout();
        t_zero();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule